// File: doc/BRIEF.md
# Oversampling Serial Transceiver

This block is a full-duplex asynchronous serial port with independent transmit and receive paths. The bit rate is set by a 12-bit divisor, split over a low byte and a high nibble. The receiver takes sixteen samples of its line per bit period. It settles every bit, including start and stop, by a two-of-three vote over the three centre samples. Frames carry a start bit, eight or nine data bits sent least significant bit first, and a single stop bit.

Software reaches the block through a small register port with a 3-bit address and separate write and read strobes. Reads are combinational. Addresses: 0 data (write loads the transmit holding register, read returns the received byte), 1 status, 2 control, 3 divisor low byte, 4 divisor high nibble. Three interrupt request lines are provided. An acknowledge input lets an interrupt controller clear the transmit-complete flag when that interrupt is serviced. A multiprocessor filter can discard received frames whose ninth bit is clear, so a listener wakes only on address frames.

Status bits: 7 receive-complete, 6 transmit-complete, 5 holding-empty, 4 framing error, 3 overrun, 0 ninth bit of the held received frame, others 0. Control bits: 7 receive irq enable, 6 transmit-complete irq enable, 5 holding-empty irq enable, 2 nine-bit frames, 1 ninth bit to transmit, 0 multiprocessor filter, others unused.

Top module: `uart_core`

## Requirements
- R1: After reset, status reads 0x20 (holding-empty only), the transmit line is high and all three interrupt requests are low.
- R2: One bit lasts 16*(D+1) clock cycles, where D is the 12-bit divisor. The high-nibble register keeps only its low 4 bits, so writing 0xF1 reads back 0x01.
- R3: A transmitted frame is a low start bit, the data bits LSB first (nine when control bit 2 is set, the ninth taken from control bit 1), then a high stop bit. The line is high whenever no frame is being sent.
- R4: Writing the data register clears holding-empty. The flag sets again when the byte is copied into the shifter. A byte written while a frame is in flight waits in the holding register and is sent right after it.
- R5: Transmit-complete sets when a stop bit ends with nothing waiting. It clears when a one is written to status bit 6 or when the acknowledge input is pulsed.
- R6: After a falling edge on an idle line, the receiver votes on start-bit samples 8, 9 and 10. If the majority is high, it drops back to idle and reports nothing.
- R7: Each received data bit is the majority of its samples 8, 9 and 10. One disturbed sample does not change the bit; two disturbed samples do.
- R8: If the stop bit's three centre samples hold fewer than two ones, the framing error flag is set with that frame. A single low sample in the stop bit does not set it.
- R9: A completed frame loads the received data (and its ninth bit into status bit 0) and sets receive-complete. Reading the data register clears receive-complete and overrun.
- R10: If a frame completes while receive-complete is still set, the overrun flag sets and the held data is kept unchanged.
- R11: With control bits 0 and 2 both set, a frame whose ninth bit is 0 changes no flag and no data. A frame whose ninth bit is 1 is accepted normally.
- R12: Each interrupt request equals its flag (receive-complete, transmit-complete, holding-empty) ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on the data register) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| txdone_ack | input | 1 | Clears transmit-complete when the interrupt is serviced |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_txdone | output | 1 | Transmit-complete interrupt request |
| irq_empty | output | 1 | Holding-empty interrupt request |

## Verification
Received frames are driven with clean bits, with one disturbed sample inside a data bit, and with two adjacent disturbed samples. The first two must decode to the same byte and the third must flip that bit, which confirms a vote over exactly the three centre samples. A low stop bit is set against a stop bit with a single low sample, which separates a true framing error from noise. A three-cycle low pulse on the idle line checks start-bit validation. Nine-bit frames with the ninth bit clear and set are sent with the filter on, to show which are dropped. On the transmit side, back-to-back writes, nine-bit frames, and divisor values using both the low and the high register are checked by decoding the line and measuring run lengths in clock cycles.

// File: rtl/uart_pkg.sv
// Shared register addresses and receiver state encoding for the serial port.
// Assumes a 3-bit register address space with five used locations.
package uart_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIVLO = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIVHI = 3'd4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/uart_baud.sv
// Oversampling tick generator: one tick every DIV+1 clocks.
// Assumes the divisor is static while frames are in flight; a smaller
// new value takes effect at once because the compare uses >=.
module uart_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count clocks and emit a single-cycle tick when the divisor is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx.sv
// Transmit shifter: takes a byte from the holding register when idle and
// sends start, 8 or 9 data bits LSB first, and stop, each OSR ticks long.
// Assumes OSR is a power of two.
module uart_tx #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       nine,
    input  logic       hold_full,
    input  logic [8:0] hold_data,
    output logic       load,
    output logic       busy,
    output logic       tx,
    output logic       frame_end
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [10:0]   shreg;
    logic [3:0]    left;
    logic [CW-1:0] cnt;

    assign load = !busy && hold_full;
    assign tx   = busy ? shreg[0] : 1'b1;

    // Load a frame when idle, then shift one bit per OSR ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '1;
            left      <= '0;
            cnt       <= '0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                cnt   <= '0;
                shreg <= nine ? {1'b1, hold_data, 1'b0}
                              : {2'b11, hold_data[7:0], 1'b0};
                left  <= nine ? 4'd11 : 4'd10;
            end else if (busy && tick) begin
                if (cnt == LAST) begin
                    cnt   <= '0;
                    shreg <= {1'b1, shreg[10:1]};
                    left  <= left - 1'b1;
                    if (left == 4'd1) begin
                        busy      <= 1'b0;
                        frame_end <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
// Receiver: finds a falling edge on the synchronised line, then settles
// every bit by a two-of-three vote over the centre samples of each
// OSR-sample bit period. Emits a one-cycle frame_valid with the data and
// a stop-bit verdict. Assumes rx_s is already synchronised to clk.
module uart_rx
    import uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_s,
    input  logic       nine,
    output logic       frame_valid,
    output logic [8:0] frame_data,
    output logic       frame_stop_bad
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] V0   = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] V1   = CW'(OSR / 2);
    localparam logic [CW-1:0] V2   = CW'(OSR / 2 + 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t     state;
    logic          prev;
    logic [CW-1:0] cnt;
    logic [1:0]    ones;
    logic [1:0]    ones_nx;
    logic          in_win;
    logic          maj;
    logic [3:0]    bit_idx;
    logic [3:0]    nbits;
    logic [8:0]    shreg;

    // Vote bookkeeping for the current sample.
    always_comb begin
        in_win  = (cnt == V0) || (cnt == V1) || (cnt == V2);
        ones_nx = ones + ((in_win && rx_s) ? 2'd1 : 2'd0);
        maj     = (ones_nx >= 2'd2);
        nbits   = nine ? 4'd9 : 4'd8;
    end

    assign frame_data = nine ? shreg : {1'b0, shreg[8:1]};

    // Frame sequencing on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= RX_IDLE;
            prev           <= 1'b1;
            cnt            <= '0;
            ones           <= '0;
            bit_idx        <= '0;
            shreg          <= '0;
            frame_valid    <= 1'b0;
            frame_stop_bad <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    prev <= rx_s;
                    if (prev && !rx_s) begin
                        state <= RX_START;
                        cnt   <= '0;
                        ones  <= '0;
                    end
                end else begin
                    cnt  <= cnt + 1'b1;
                    ones <= ones_nx;
                    if (cnt == V2) begin
                        if (state == RX_START && maj) begin
                            state <= RX_IDLE;
                            prev  <= rx_s;
                        end else if (state == RX_DATA) begin
                            shreg   <= {maj, shreg[8:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end else if (state == RX_STOP) begin
                            frame_valid    <= 1'b1;
                            frame_stop_bad <= !maj;
                            state          <= RX_IDLE;
                            prev           <= rx_s;
                        end
                    end
                    if (cnt == LAST) begin
                        cnt  <= '0;
                        ones <= '0;
                        if (state == RX_START) begin
                            state   <= RX_DATA;
                            bit_idx <= '0;
                        end else if (state == RX_DATA && bit_idx == nbits) begin
                            state <= RX_STOP;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_core.sv
// Full-duplex serial port top: register port, flags, interrupt requests,
// baud tick, transmit shifter and voting receiver. Assumes DIV_W is
// between 9 and 16 so the divisor spans a low byte and a high field.
module uart_core
    import uart_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int OSR   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              rx_in,
    output logic              tx_out,
    input  logic              txdone_ack,
    output logic              irq_rx,
    output logic              irq_txdone,
    output logic              irq_empty
);
    localparam int HI_W = DIV_W - 8;

    logic [7:0]       ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [8:0]       hold_q;
    logic             hold_full;
    logic             tx_done_q;
    logic [8:0]       rx_data_q;
    logic             rx_done_q;
    logic             ferr_q;
    logic             ovr_q;
    logic [1:0]       rx_sync;
    logic             tick;
    logic             tx_load;
    logic             tx_busy;
    logic             tx_frame_end;
    logic             rx_valid;
    logic [8:0]       rx_word;
    logic             rx_stop_bad;
    logic             rx_accept;
    logic             wr_data;
    logic             rd_data;

    assign wr_data   = wr_en && (addr == A_DATA);
    assign rd_data   = rd_en && (addr == A_DATA);
    assign rx_accept = rx_valid && !(ctrl_q[0] && ctrl_q[2] && !rx_word[8]);

    assign irq_rx     = rx_done_q && ctrl_q[7];
    assign irq_txdone = tx_done_q && ctrl_q[6];
    assign irq_empty  = !hold_full && ctrl_q[5];

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (div_q),
        .tick (tick)
    );

    uart_tx #(.OSR(OSR)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .nine     (ctrl_q[2]),
        .hold_full(hold_full),
        .hold_data(hold_q),
        .load     (tx_load),
        .busy     (tx_busy),
        .tx       (tx_out),
        .frame_end(tx_frame_end)
    );

    uart_rx #(.OSR(OSR)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .rx_s          (rx_sync[1]),
        .nine          (ctrl_q[2]),
        .frame_valid   (rx_valid),
        .frame_data    (rx_word),
        .frame_stop_bad(rx_stop_bad)
    );

    // Two-flop synchroniser for the asynchronous receive line.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= 2'b11;
        else        rx_sync <= {rx_sync[0], rx_in};
    end

    // Control and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL)  ctrl_q      <= wdata;
            if (addr == A_DIVLO) div_q[7:0]  <= wdata;
            if (addr == A_DIVHI) div_q[DIV_W-1:8] <= wdata[HI_W-1:0];
        end
    end

    // Transmit holding register and transmit-complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            tx_done_q <= 1'b0;
        end else begin
            if (wr_data) begin
                hold_q    <= {ctrl_q[1], wdata};
                hold_full <= 1'b1;
            end else if (tx_load) begin
                hold_full <= 1'b0;
            end
            if (tx_frame_end && !hold_full)
                tx_done_q <= 1'b1;
            else if (txdone_ack || (wr_en && addr == A_STAT && wdata[6]))
                tx_done_q <= 1'b0;
        end
    end

    // Receive data register and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_q <= '0;
            rx_done_q <= 1'b0;
            ferr_q    <= 1'b0;
            ovr_q     <= 1'b0;
        end else if (rx_accept && (!rx_done_q || rd_data)) begin
            rx_data_q <= rx_word;
            rx_done_q <= 1'b1;
            ferr_q    <= rx_stop_bad;
            ovr_q     <= 1'b0;
        end else if (rx_accept) begin
            ovr_q <= 1'b1;
        end else if (rd_data) begin
            rx_done_q <= 1'b0;
            ovr_q     <= 1'b0;
        end
    end

    // Combinational read multiplexer.
    always_comb begin
        case (addr)
            A_DATA:  rdata = rx_data_q[7:0];
            A_STAT:  rdata = {rx_done_q, tx_done_q, !hold_full, ferr_q, ovr_q,
                              2'b00, rx_data_q[8]};
            A_CTRL:  rdata = ctrl_q;
            A_DIVLO: rdata = div_q[7:0];
            A_DIVHI: rdata = {{(16 - DIV_W){1'b0}}, div_q[DIV_W-1:8]};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/uart_core_chk.sv
// Property checker for uart_core, attached by bind. Observes ports and
// the flags that separate processes drive; drives nothing.
module uart_core_chk
    import uart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wdata,
    input logic              tx_out,
    input logic              irq_rx,
    input logic [7:0]        ctrl_q,
    input logic              rx_done_q,
    input logic              tx_done_q,
    input logic              hold_full,
    input logic              ovr_q,
    input logic [8:0]        rx_data_q,
    input logic              tx_load,
    input logic              tx_busy,
    input logic              tx_frame_end,
    input logic              rx_accept
);
    // R9: reading the data register clears receive-complete.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_DATA && !rx_accept) |=> !rx_done_q);

    // R5: writing a one to status bit 6 clears transmit-complete.
    a_r5_wr1_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT && wdata[6] && !tx_frame_end) |=> !tx_done_q);

    // R3: the line idles high.
    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_out);

    // R10: a frame over unread data sets overrun and keeps the data.
    a_r10_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_accept && rx_done_q && !(rd_en && addr == A_DATA))
        |=> (ovr_q && $stable(rx_data_q)));

    // R4: a copy into the shifter empties the holding register.
    a_r4_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !(wr_en && addr == A_DATA)) |=> !hold_full);

    // R12: no receive interrupt without its enable.
    a_r12_rx_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !irq_rx);
endmodule

bind uart_core uart_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .tx_out      (tx_out),
    .irq_rx      (irq_rx),
    .ctrl_q      (ctrl_q),
    .rx_done_q   (rx_done_q),
    .tx_done_q   (tx_done_q),
    .hold_full   (hold_full),
    .ovr_q       (ovr_q),
    .rx_data_q   (rx_data_q),
    .tx_load     (tx_load),
    .tx_busy     (tx_busy),
    .tx_frame_end(tx_frame_end),
    .rx_accept   (rx_accept)
);

// File: tb/tb_uart_core.sv
module tb_uart_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rx_line = 1'b1;
    logic       tx_out;
    logic       txdone_ack = 1'b0;
    logic       irq_rx, irq_txdone, irq_empty;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    int          bit_clks = 16;
    int          mon_bits = 10;
    int          mon_n = 0;
    logic [10:0] mon_w;
    logic [10:0] mon_log [16];

    always #5 clk = ~clk;

    uart_core dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_in(rx_line), .tx_out(tx_out),
        .txdone_ack(txdone_ack), .irq_rx(irq_rx), .irq_txdone(irq_txdone),
        .irq_empty(irq_empty)
    );

    // Vector: ctrl, 9-bit data, stop level, glitch bit index, glitch length,
    // expected data read, expected status read.
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 9'h0A5, 1'b1, 4'd0, 2'd0, 8'hA5, 8'hA0},  // R9 clean byte
        {8'h00, 9'h03C, 1'b1, 4'd4, 2'd1, 8'h3C, 8'hA0},  // R7 one bad sample
        {8'h00, 9'h03C, 1'b1, 4'd3, 2'd2, 8'h38, 8'hA0},  // R7 two bad samples
        {8'h00, 9'h055, 1'b0, 4'd0, 2'd0, 8'h55, 8'hB0},  // R8 low stop
        {8'h00, 9'h00F, 1'b1, 4'd9, 2'd1, 8'h0F, 8'hA0},  // R8 stop noise
        {8'h04, 9'h1C3, 1'b1, 4'd0, 2'd0, 8'hC3, 8'hA1},  // R9 nine bits
        {8'h05, 9'h0AA, 1'b1, 4'd0, 2'd0, 8'hC3, 8'h21},  // R11 dropped
        {8'h05, 9'h1F0, 1'b1, 4'd0, 2'd0, 8'hF0, 8'hA1}   // R11 address
    };

    task automatic check(input string tag, input int got, input int exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_rx(input logic [8:0] d, input logic nine, input logic stopv,
                           input int gidx, input int glen);
        int nb;
        nb = nine ? 9 : 8;
        for (int k = 0; k < nb + 2; k++) begin
            logic v;
            if (k == 0)           v = 1'b0;
            else if (k == nb + 1) v = stopv;
            else                  v = d[k-1];
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                rx_line = v ^ ((k == gidx) && (j >= 8) && (j < 8 + glen));
            end
        end
        @(negedge clk);
        rx_line = 1'b1;
    endtask

    task automatic low_run(output int n);
        do @(negedge clk); while (tx_out !== 1'b0);
        do @(negedge clk); while (tx_out !== 1'b1);
        do @(negedge clk); while (tx_out !== 1'b0);
        n = 0;
        while (tx_out === 1'b0) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_frames(input int n);
        while (mon_n < n) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    function automatic logic [10:0] frame_of(input logic [8:0] d, input logic nine);
        return nine ? {1'b1, d, 1'b0} : {1'b0, 1'b1, d[7:0], 1'b0};
    endfunction

    // Line monitor: decodes frames on tx_out at bit centres.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                mon_w = '0;
                repeat (bit_clks / 2) @(negedge clk);
                mon_w[0] = tx_out;
                for (int k = 1; k < mon_bits; k++) begin
                    repeat (bit_clks) @(negedge clk);
                    mon_w[k] = tx_out;
                end
                mon_log[mon_n % 16] = mon_w;
                mon_n++;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, v);
        check("R1 status", v, 8'h20);
        check("R1 tx line", tx_out, 1);
        check("R1 irqs", {irq_rx, irq_txdone, irq_empty}, 0);

        // Receive vectors at divisor 0
        for (int i = 0; i < NV; i++) begin
            wr(3'd2, VEC[i][39:32]);
            send_rx(VEC[i][31:23], VEC[i][34], VEC[i][22], int'(VEC[i][21:18]),
                    int'(VEC[i][17:16]));
            repeat (20) @(negedge clk);
            rd(3'd1, v);
            check($sformatf("R9 vector %0d status", i), v, VEC[i][7:0]);
            rd(3'd0, v);
            check($sformatf("R9 vector %0d data", i), v, VEC[i][15:8]);
        end
        wr(3'd2, 8'h00);

        // R10 overrun then R9 clearing
        send_rx(9'h011, 1'b0, 1'b1, 0, 0);
        send_rx(9'h022, 1'b0, 1'b1, 0, 0);
        repeat (20) @(negedge clk);
        rd(3'd1, v);
        check("R10 status", v, 8'hA8);
        rd(3'd0, v);
        check("R10 held data", v, 8'h11);
        rd(3'd1, v);
        check("R9 flags cleared by read", v, 8'h20);

        // R6 short low pulse is not a start bit
        repeat (3) begin
            @(negedge clk);
            rx_line = 1'b0;
        end
        @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        rd(3'd1, v);
        check("R6 false start", v, 8'h20);

        // R12 interrupt gating
        wr(3'd2, 8'h80);
        send_rx(9'h033, 1'b0, 1'b1, 0, 0);
        repeat (20) @(negedge clk);
        check("R12 irq_rx set", irq_rx, 1);
        rd(3'd0, v);
        @(negedge clk);
        check("R12 irq_rx cleared", irq_rx, 0);
        wr(3'd2, 8'h20);
        check("R12 irq_empty enabled", irq_empty, 1);
        wr(3'd2, 8'h00);
        check("R12 irq_empty disabled", irq_empty, 0);

        // R3/R4 transmit, back to back
        wr(3'd0, 8'h5A);
        rd(3'd1, v);
        check("R4 empty after copy", v, 8'h20);
        wr(3'd0, 8'hC3);
        rd(3'd1, v);
        check("R4 queued byte", v, 8'h00);
        wait_frames(2);
        rd(3'd1, v);
        check("R5 done set", v, 8'h60);
        check("R3 frame 1", mon_log[0], frame_of(9'h05A, 1'b0));
        check("R3 frame 2", mon_log[1], frame_of(9'h0C3, 1'b0));
        wr(3'd2, 8'h40);
        check("R12 irq_txdone", irq_txdone, 1);
        wr(3'd1, 8'h40);
        rd(3'd1, v);
        check("R5 write one clears", v, 8'h20);
        check("R12 irq_txdone low", irq_txdone, 0);

        // R3 nine-bit transmit, R5 acknowledge clear
        wr(3'd2, 8'h06);
        mon_bits = 11;
        wr(3'd0, 8'h81);
        wait_frames(3);
        check("R3 nine-bit frame", mon_log[2], frame_of(9'h181, 1'b1));
        rd(3'd1, v);
        check("R5 done after nine-bit", v, 8'h60);
        @(negedge clk);
        txdone_ack = 1'b1;
        @(negedge clk);
        txdone_ack = 1'b0;
        rd(3'd1, v);
        check("R5 ack clears", v, 8'h20);

        // R2 baud divisor
        wr(3'd2, 8'h00);
        mon_bits = 10;
        bit_clks = 48;
        wr(3'd3, 8'h02);
        wr(3'd0, 8'h01);
        low_run(n);
        check("R2 seven bits at divisor 2", n, 7 * 48);
        wait_frames(4);
        check("R2 frame at divisor 2", mon_log[3], frame_of(9'h001, 1'b0));
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hF1);
        rd(3'd4, v);
        check("R2 high field width", v, 8'h01);
        bit_clks = 16 * 257;
        wr(3'd0, 8'h01);
        low_run(n);
        check("R2 seven bits at divisor 0x100", n, 7 * 16 * 257);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule